// File: doc/BRIEF.md
# Capture/Compare/PWM Unit

This unit sits beside two timers, a free-running 16-bit counter and an 8-bit period counter with a 2-bit prescaler phase. It never counts by itself. It watches those counts and acts on them in one of three ways, chosen by a 4-bit mode held in a 6-bit control word.

In capture mode the unit watches a synchronised input pin and stores the 16-bit count on a chosen edge. The edge can be every falling edge, every rising edge, or every 4th or 16th rising edge. In compare mode it watches for the 16-bit count to reach the stored value, then sets or clears the output pin, raises an interrupt request, or emits a special-event trigger. In PWM mode it builds a 10-bit duty value from the upper byte of the stored register and two fraction bits of the control word. It raises the output pin at each period start and drops it once the duty count has elapsed.

Software loads the control word and the 16-bit register through plain write strobes. The register's present value is visible at an output port.

Top module: `ccp_unit`

## Requirements
- R1: After reset the output pin, the interrupt pulse and the special-event pulse are low, the register reads zero and the mode is off.
- R2: In the off modes (mode bits 3:2 = 00) the output pin is low, input pin edges raise no interrupt and leave the register unchanged.
- R3: The input pin passes through a two-flop synchroniser. Mode 0100 captures on each falling edge and mode 0101 on each rising edge. A capture copies the 16-bit timer into the register and gives a one-cycle interrupt pulse, three clock edges after the pin changes.
- R4: Mode 0110 captures on every 4th synchronised rising edge and mode 0111 on every 16th. The edges in between change nothing.
- R5: A control write whose mode differs from the current mode restarts the edge prescale count from zero.
- R6: In compare mode (bits 3:2 = 10), the cycle in which the timer comes to equal the register is a match. On a match, mode 1000 drives the pin high and mode 1001 drives it low, and each gives one interrupt pulse. A timer that stays equal gives no further match.
- R7: On a match, mode 1010 gives only an interrupt pulse and leaves the pin as it was. Mode 1011 gives an interrupt pulse and a one-cycle special-event pulse. No other mode produces the special-event pulse.
- R8: Mode bits 3:2 = 11 select PWM. The control word carries the duty fraction in bits 5:4 and the mode in bits 3:0. The duty is register[15:8]*4 + fraction. Each period-wrap strobe starts a period with the pin high, and the pin stays high for exactly duty clock cycles of the 10-bit count {period timer, phase}.
- R9: The duty is copied into a shadow at each period start. A register or fraction write made mid-period takes effect only in the following period.
- R10: A duty of zero keeps the pin low for the whole period. A duty equal to or larger than the period length keeps it high for the whole period.
- R11: Turning the unit off from a compare state with the pin high drives the pin low at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 6 | Control word: fraction in 5:4, mode in 3:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write value |
| tmr_val | input | 16 | Free-running timer count |
| prd_val | input | 8 | Period timer count |
| prd_phase | input | 2 | Period timer prescaler phase |
| prd_wrap | input | 1 | High in the cycle the period timer wraps to zero |
| pin_in | input | 1 | Capture input pin (asynchronous) |
| pin_out | output | 1 | Output pin drive |
| irq | output | 1 | One-cycle interrupt request pulse |
| evt | output | 1 | One-cycle special-event pulse |
| ccpr | output | 16 | Capture/compare register value |

## Verification
The bench drives every capture mode with clean, widely spaced pulses and steps the timer between pulses. A prescaler that miscounts by one therefore stores a visibly wrong timer value or the wrong number of interrupts. A counter that survived a mode change fires two edges early. In compare mode the timer is held equal across mode switches, so a design that acted on level rather than the transition would change the pin or double-count interrupts. The special-event pulse is counted in every mode. For PWM, high cycles are counted across one full period for a mid-range duty, a zero duty, and a duty past the period end. A duty write made inside a period must leave that period's count at the old value; a design without the shadow would show a blend of old and new.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef enum logic [1:0] {
    GRP_OFF = 2'b00,
    GRP_CAP = 2'b01,
    GRP_CMP = 2'b10,
    GRP_PWM = 2'b11
  } ccp_grp_e;

  // low two mode bits inside the capture group
  localparam logic [1:0] CAP_FALL  = 2'b00;
  localparam logic [1:0] CAP_RISE  = 2'b01;
  localparam logic [1:0] CAP_RISE4 = 2'b10;
  localparam logic [1:0] CAP_RISE16 = 2'b11;

  // low two mode bits inside the compare group
  localparam logic [1:0] CMP_SET  = 2'b00;
  localparam logic [1:0] CMP_CLR  = 2'b01;
  localparam logic [1:0] CMP_IRQ  = 2'b10;
  localparam logic [1:0] CMP_TRIG = 2'b11;

endpackage

// File: rtl/ccp_edge_cap.sv
module ccp_edge_cap
  import ccp_pkg::*;
#(
  parameter int QUAD_N = 4,
  parameter int HEX_N  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       clr,
  input  logic [1:0] sel,
  input  logic       pin_in,
  output logic       fire
);
  localparam int PSC_W = $clog2(HEX_N);
  localparam logic [PSC_W-1:0] LIM_QUAD = PSC_W'(QUAD_N - 1);
  localparam logic [PSC_W-1:0] LIM_HEX  = PSC_W'(HEX_N - 1);

  logic [1:0]       sync_q;
  logic             last_q;
  logic [PSC_W-1:0] cnt_q, cnt_d;
  logic [PSC_W-1:0] limit;
  logic             rise, fall, hit;

  always_comb begin
    rise = sync_q[1] & ~last_q;
    fall = ~sync_q[1] & last_q;
    hit  = (sel == CAP_FALL) ? fall : rise;
    case (sel)
      CAP_RISE4:  limit = LIM_QUAD;
      CAP_RISE16: limit = LIM_HEX;
      default:    limit = '0;
    endcase
    fire  = en & ~clr & hit & (cnt_q == limit);
    cnt_d = cnt_q;
    if (!en || clr)  cnt_d = '0;
    else if (hit)    cnt_d = (cnt_q == limit) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_in};
      last_q <= sync_q[1];
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              prd_wrap,
  input  logic [DUTY_W-1:0] cnt,
  input  logic [DUTY_W-1:0] duty,
  output logic              pin
);
  logic [DUTY_W-1:0] shadow_q, shadow_d;
  logic              pin_q, pin_d;
  logic [DUTY_W:0]   cnt_nx;

  always_comb begin
    cnt_nx   = {1'b0, cnt} + 1'b1;
    shadow_d = shadow_q;
    pin_d    = pin_q;
    if (!en) begin
      shadow_d = '0;
      pin_d    = 1'b0;
    end else if (prd_wrap) begin
      shadow_d = duty;
      pin_d    = (duty != '0);
    end else if (pin_q && (cnt_nx == {1'b0, shadow_q})) begin
      pin_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pin_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      pin_q    <= pin_d;
    end
  end

  assign pin = pin_q;

  AST_PWM_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && shadow_q == '0) |-> !pin_q); // R10

  AST_PWM_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && prd_wrap) |=> (pin_q == ($past(duty) != '0))); // R8

endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int PRD_W  = 8,
  parameter int FRAC_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ctrl_wr,
  input  logic [FRAC_W+3:0]     ctrl_wdata,
  input  logic                  reg_wr,
  input  logic [TMR_W-1:0]      reg_wdata,
  input  logic [TMR_W-1:0]      tmr_val,
  input  logic [PRD_W-1:0]      prd_val,
  input  logic [FRAC_W-1:0]     prd_phase,
  input  logic                  prd_wrap,
  input  logic                  pin_in,
  output logic                  pin_out,
  output logic                  irq,
  output logic                  evt,
  output logic [TMR_W-1:0]      ccpr
);
  localparam int DUTY_W = PRD_W + FRAC_W;

  logic [3:0]        mode_q, mode_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [TMR_W-1:0]  ccpr_q, ccpr_d;
  logic              match_q, match;
  logic              cmp_pin_q, cmp_pin_d;
  logic              irq_q, irq_d, evt_q, evt_d;
  logic              mode_chg, cap_fire, cmp_hit, pwm_pin;
  ccp_grp_e          grp;

  assign grp      = ccp_grp_e'(mode_q[3:2]);
  assign mode_chg = ctrl_wr && (ctrl_wdata[3:0] != mode_q);
  assign match    = (grp == GRP_CMP) && (tmr_val == ccpr_q);
  assign cmp_hit  = match && !match_q;

  ccp_edge_cap u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (grp == GRP_CAP),
    .clr   (mode_chg),
    .sel   (mode_q[1:0]),
    .pin_in(pin_in),
    .fire  (cap_fire)
  );

  ccp_pwm #(.DUTY_W(DUTY_W)) u_pwm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (grp == GRP_PWM),
    .prd_wrap(prd_wrap),
    .cnt     ({prd_val, prd_phase}),
    .duty    ({ccpr_q[TMR_W-1 -: PRD_W], frac_q}),
    .pin     (pwm_pin)
  );

  always_comb begin
    mode_d = mode_q;
    frac_d = frac_q;
    if (ctrl_wr) begin
      mode_d = ctrl_wdata[3:0];
      frac_d = ctrl_wdata[FRAC_W+3:4];
    end

    ccpr_d = ccpr_q;
    if (reg_wr)        ccpr_d = reg_wdata;
    else if (cap_fire) ccpr_d = tmr_val;

    cmp_pin_d = cmp_pin_q;
    if (grp != GRP_CMP)                              cmp_pin_d = 1'b0;
    else if (cmp_hit && mode_q[1:0] == CMP_SET)      cmp_pin_d = 1'b1;
    else if (cmp_hit && mode_q[1:0] == CMP_CLR)      cmp_pin_d = 1'b0;

    irq_d = cap_fire || cmp_hit;
    evt_d = cmp_hit && (mode_q[1:0] == CMP_TRIG);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      frac_q    <= '0;
      ccpr_q    <= '0;
      match_q   <= 1'b0;
      cmp_pin_q <= 1'b0;
      irq_q     <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      frac_q    <= frac_d;
      ccpr_q    <= ccpr_d;
      match_q   <= match;
      cmp_pin_q <= cmp_pin_d;
      irq_q     <= irq_d;
      evt_q     <= evt_d;
    end
  end

  always_comb begin
    case (grp)
      GRP_CMP: pin_out = cmp_pin_q;
      GRP_PWM: pin_out = pwm_pin;
      default: pin_out = 1'b0;
    endcase
  end

  assign irq  = irq_q;
  assign evt  = evt_q;
  assign ccpr = ccpr_q;

  AST_CAP_LOADS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !reg_wr) |=> (ccpr_q == $past(tmr_val))); // R3

  AST_IRQ_FROM_ACTIVE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(grp == GRP_CAP || grp == GRP_CMP)); // R2

  AST_EVT_ONLY_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> ($past(mode_q) == 4'b1011)); // R7

endmodule

// File: tb/ccp_unit_tb.sv
`timescale 1ns/1ps
module ccp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_wr;
  logic [5:0]  ctrl_wdata;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] tmr_val;
  logic        pin_in;
  logic        pin_out, irq, evt;
  logic [15:0] ccpr;
  logic [9:0]  pcnt;
  logic        prd_wrap;

  localparam int PLEN = 40;   // (period register 9 + 1) * 4 phases

  int n_run = 0, n_fail = 0;
  int irq_cnt = 0, evt_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign prd_wrap = (pcnt == 10'(PLEN - 1));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) pcnt <= '0;
    else        pcnt <= prd_wrap ? '0 : pcnt + 1'b1;

  always @(negedge clk) begin
    if (rst_n && irq) irq_cnt++;
    if (rst_n && evt) evt_cnt++;
  end

  ccp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .tmr_val(tmr_val),
    .prd_val(pcnt[9:2]), .prd_phase(pcnt[1:0]), .prd_wrap(prd_wrap),
    .pin_in(pin_in), .pin_out(pin_out), .irq(irq), .evt(evt), .ccpr(ccpr)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [5:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic wr_reg(input logic [15:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  // one high pulse on the input pin, timer held at t across both edges
  task automatic pulse(input logic [15:0] t);
    @(negedge clk); tmr_val = t; pin_in = 1'b1;
    repeat (4) @(negedge clk);
    pin_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // count high cycles over one whole PWM period; optional mid-period duty write
  task automatic pwm_measure(output int hi, input bit mid,
                             input logic [15:0] r, input logic [5:0] c);
    hi = 0;
    do @(negedge clk); while (!prd_wrap);
    for (int i = 0; i < PLEN; i++) begin
      @(negedge clk);
      if (pin_out) hi++;
      if (mid && i == 5) begin reg_wr = 1'b1; reg_wdata = r; end
      if (mid && i == 6) begin reg_wr = 1'b0; ctrl_wr = 1'b1; ctrl_wdata = c; end
      if (mid && i == 7) ctrl_wr = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R1 pin", pin_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 evt", evt, 0);
    chk("R1 reg", ccpr, 0);
  endtask

  task automatic t_off;
    int i0 = irq_cnt;
    pulse(16'h1111);
    pulse(16'h2222);
    chk("R2 reg unchanged", ccpr, 0);
    chk("R2 no irq", irq_cnt - i0, 0);
    chk("R2 pin low", pin_out, 0);
  endtask

  task automatic t_cap_single;
    int i0;
    wr_ctrl(6'b00_0100);
    i0 = irq_cnt;
    @(negedge clk); tmr_val = 16'h1234; pin_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 falling mode ignores rise", ccpr, 0);
    pin_in = 1'b0;
    // change at negedge, capture lands at third following edge
    repeat (2) @(negedge clk);
    chk("R3 not before third edge", ccpr, 0);
    @(negedge clk);
    chk("R3 falling capture", ccpr, 16'h1234);
    chk("R3 irq pulse", irq, 1);
    repeat (3) @(negedge clk);
    chk("R3 one irq", irq_cnt - i0, 1);
    wr_ctrl(6'b00_0101);
    pulse(16'hA0A0);
    chk("R3 rising capture", ccpr, 16'hA0A0);
  endtask

  task automatic t_cap_prescale;
    int i0;
    wr_ctrl(6'b00_0110);
    i0 = irq_cnt;
    for (int k = 1; k <= 8; k++) begin
      pulse(16'(k));
      if (k == 3) chk("R4 div4 no capture at 3rd", ccpr, 16'hA0A0);
      if (k == 4) chk("R4 div4 capture at 4th", ccpr, 4);
    end
    chk("R4 div4 capture at 8th", ccpr, 8);
    chk("R4 div4 irq count", irq_cnt - i0, 2);
    wr_ctrl(6'b00_0111);
    i0 = irq_cnt;
    for (int k = 1; k <= 16; k++) begin
      pulse(16'h0100 + 16'(k));
      if (k == 15) chk("R4 div16 no capture at 15th", ccpr, 8);
    end
    chk("R4 div16 capture at 16th", ccpr, 16'h0110);
    chk("R4 div16 irq count", irq_cnt - i0, 1);
  endtask

  task automatic t_prescale_restart;
    wr_ctrl(6'b00_0110);
    pulse(16'h0201);
    pulse(16'h0202);
    wr_ctrl(6'b00_0111);
    wr_ctrl(6'b00_0110);
    for (int k = 1; k <= 3; k++) pulse(16'h0300 + 16'(k));
    chk("R5 count restarted", ccpr, 16'h0110);
    pulse(16'h0304);
    chk("R5 capture at 4th after change", ccpr, 16'h0304);
  endtask

  task automatic t_compare;
    int i0, e0;
    @(negedge clk); tmr_val = 16'h00FF;
    wr_reg(16'h0100);
    wr_ctrl(6'b00_1000);
    i0 = irq_cnt; e0 = evt_cnt;
    chk("R6 pin low before match", pin_out, 0);
    @(negedge clk); tmr_val = 16'h0100;
    repeat (2) @(negedge clk);
    chk("R6 set on match", pin_out, 1);
    repeat (3) @(negedge clk);
    chk("R6 held equal single irq", irq_cnt - i0, 1);
    wr_ctrl(6'b00_1001);
    repeat (2) @(negedge clk);
    chk("R6 no action while equal", pin_out, 1);
    @(negedge clk); tmr_val = 16'h0101;
    @(negedge clk); tmr_val = 16'h0100;
    repeat (2) @(negedge clk);
    chk("R6 clear on match", pin_out, 0);
    wr_ctrl(6'b00_1000);
    @(negedge clk); tmr_val = 16'h0101;
    @(negedge clk); tmr_val = 16'h0100;
    repeat (2) @(negedge clk);
    chk("R6 set again", pin_out, 1);
    chk("R6 irq total", irq_cnt - i0, 3);
    wr_ctrl(6'b00_1010);
    @(negedge clk); tmr_val = 16'h0101;
    @(negedge clk); tmr_val = 16'h0100;
    repeat (2) @(negedge clk);
    chk("R7 irq-only keeps pin", pin_out, 1);
    chk("R7 irq-only irq", irq_cnt - i0, 4);
    chk("R7 no evt outside trigger", evt_cnt - e0, 0);
    wr_ctrl(6'b00_1011);
    @(negedge clk); tmr_val = 16'h0101;
    @(negedge clk); tmr_val = 16'h0100;
    repeat (2) @(negedge clk);
    chk("R7 trigger evt", evt_cnt - e0, 1);
    chk("R7 trigger irq", irq_cnt - i0, 5);
    chk("R7 trigger keeps pin", pin_out, 1);
    wr_ctrl(6'b00_0000);
    chk("R11 off drives low", pin_out, 0);
  endtask

  task automatic t_pwm;
    int hi;
    int e0 = evt_cnt;
    wr_reg(16'h0300);
    wr_ctrl(6'b10_1100);               // duty 3*4+2 = 14
    pwm_measure(hi, 0, 16'h0, 6'h0);
    pwm_measure(hi, 0, 16'h0, 6'h0);
    chk("R8 duty 14 high cycles", hi, 14);
    pwm_measure(hi, 1, 16'h0700, 6'b10_1100);  // write duty 30 mid-period
    chk("R9 mid write deferred", hi, 14);
    pwm_measure(hi, 0, 16'h0, 6'h0);
    chk("R9 new duty next period", hi, 30);
    wr_reg(16'h0000);
    wr_ctrl(6'b00_1100);
    pwm_measure(hi, 0, 16'h0, 6'h0);
    pwm_measure(hi, 0, 16'h0, 6'h0);
    chk("R10 zero duty low", hi, 0);
    wr_reg(16'h0C00);
    wr_ctrl(6'b10_1100);               // duty 50 > period 40
    pwm_measure(hi, 0, 16'h0, 6'h0);
    pwm_measure(hi, 0, 16'h0, 6'h0);
    chk("R10 duty past period high", hi, PLEN);
    chk("R7 no evt in pwm", evt_cnt - e0, 0);
  endtask

  initial begin
    rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_wdata = '0; reg_wr = 1'b0;
    reg_wdata = '0; tmr_val = '0; pin_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_off();
    t_cap_single();
    t_cap_prescale();
    t_prescale_restart();
    t_compare();
    t_pwm();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule